// File: doc/BRIEF.md
# Multi-error correction sequencer for a 512-byte sector

This block runs the correction pass after a 512-byte sector has been read from flash. The sector is guarded by a code that can repair up to four byte errors. A single start pulse launches the pass. The block first unpacks the stored 80-bit check field into eight 10-bit words. It hands these words to an external error locator, one per cycle, starting at the highest index.

Next it looks at the syndrome. A zero syndrome means the sector is clean, and the pass ends without starting the locator. A nonzero syndrome makes the block kick the locator and wait for a result. The locator reports a short false "ready" right after it is started, so the block waits for the locator's state to reach 4 or more before it trusts any result. This initial wait is bounded by a timeout of about 100 µs.

Once the locator reports locations, the block converts each one into a byte offset. Offsets that fall outside the data bytes are dropped. For each remaining error, the block XORs the error value into the sector RAM with a read cycle followed by a write cycle. At the end it pulses done and reports either the number of bytes corrected or an uncorrectable flag.

Top module: `ecc_fix_seq`

## Requirements
- R1: The check field `chk_i` holds the stored check bytes little-endian, with byte j at bits [8j+7:8j]. Check word k is taken from bits [10k+9:10k].
- R2: After `start_i`, the eight check words appear on `ld_data_o` with `ld_valid_o` high. There is one word per cycle, in index order 7, 6, …, 0.
- R3: If `syn_i` is all zero, `loc_go_o` never pulses. `done_o` pulses with `fixed_o`=0 and `bad_o`=0, and the RAM is not touched.
- R4: If `syn_i` is nonzero, `loc_go_o` pulses once. Locator states below 4, including a false 3, are not taken as a result until a state of 4 or more has been seen.
- R5: If the state stays below 4 for CLK_HZ/1e6·100 cycles (10000 at the default) after the kick, the initial wait ends and the completion poll starts.
- R6: In the poll, the locator state is read as follows. State 0 ends the pass with no correction. State 1 ends it with `bad_o`=1. State 2 or 3 starts correction of 1+`loc_cnt_i` errors. Any state of 4 or more keeps polling.
- R7: Errors 0 and 1 are taken from `loc_addr1_i`/`loc_val1_i`, and errors 2 and 3 from `loc_addr2_i`/`loc_val2_i`. Even-numbered errors use the lower half (location [9:0], value [7:0]). Odd-numbered errors use the upper half (location [25:16], value [23:16]).
- R8: The byte offset is 519 minus the raw location. A result outside 0..511 is skipped and is not counted.
- R9: Errors are handled in index order. Each correction drives `ram_rd_o` with the offset. In the next cycle it drives `ram_wr_o` at the same offset with `ram_rdata_i` XOR the error value.
- R10: `done_o` pulses for one cycle after the last correction. `fixed_o` then holds the number of bytes written, and `bad_o` is set only for an uncorrectable sector.
- R11: During and after reset, all strobes are low and `fixed_o` and `bad_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts one correction pass (taken when idle) |
| chk_i | input | 80 | Stored check bytes, little-endian |
| ld_valid_o | output | 1 | Check word valid toward the locator |
| ld_data_o | output | 10 | Check word toward the locator |
| syn_i | input | 128 | Four syndrome words |
| loc_go_o | output | 1 | One-cycle start for the locator |
| loc_state_i | input | 4 | Locator state |
| loc_cnt_i | input | 2 | Error count minus one |
| loc_addr1_i | input | 32 | Locations of errors 0 and 1 |
| loc_addr2_i | input | 32 | Locations of errors 2 and 3 |
| loc_val1_i | input | 32 | Values of errors 0 and 1 |
| loc_val2_i | input | 32 | Values of errors 2 and 3 |
| ram_rd_o | output | 1 | Sector RAM read strobe |
| ram_wr_o | output | 1 | Sector RAM write strobe |
| ram_addr_o | output | 9 | Sector RAM byte address |
| ram_rdata_i | input | 8 | Read data, valid the cycle after `ram_rd_o` |
| ram_wdata_o | output | 8 | Write data |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| fixed_o | output | 3 | Bytes corrected in the last pass |
| bad_o | output | 1 | Last pass was uncorrectable |

## Verification
The assertions assume that `chk_i` and `syn_i` stay stable from the start pulse until the kick. They also assume that `start_i` is only raised while the block is idle, and that the RAM returns read data exactly one cycle after the read strobe.

The bench holds these inputs steady for the whole pass and pulses start only after the previous done. Its locator model drives a false state 3 and then a busy code after each kick. It keeps the location words at zero until the real result is shown, so taking the result too early would show up as a wrong count. The model also holds state 3 for longer than the timeout to exercise the timeout path.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LOAD,
        PH_SYN,
        PH_KICK,
        PH_WAIT,
        PH_POLL,
        PH_PICK,
        PH_RD,
        PH_WR,
        PH_FIN
    } phase_t;

    localparam logic [3:0] LOC_CLEAN  = 4'd0;
    localparam logic [3:0] LOC_FAIL   = 4'd1;
    localparam logic [3:0] LOC_READYA = 4'd2;
    localparam logic [3:0] LOC_READYB = 4'd3;
    localparam logic [3:0] LOC_WORKING = 4'd4;
endpackage

// File: rtl/ecc_unpack.sv
module ecc_unpack #(
    parameter int NVAL = 8,
    parameter int LW   = 10
) (
    input  logic [NVAL*LW-1:0]         bits_i,
    output logic [NVAL-1:0][LW-1:0]    vals_o
);
    for (genvar g = 0; g < NVAL; g++) begin : g_slice
        assign vals_o[g] = bits_i[g*LW +: LW];
    end
endmodule

// File: rtl/ecc_err_pick.sv
module ecc_err_pick #(
    parameter int WW   = 32,
    parameter int LW   = 10,
    parameter int DW   = 8,
    parameter int SECT = 512,
    parameter int OFFW = 9
) (
    input  logic [1:0]      sel_i,
    input  logic [WW-1:0]   addr1_i,
    input  logic [WW-1:0]   addr2_i,
    input  logic [WW-1:0]   val1_i,
    input  logic [WW-1:0]   val2_i,
    output logic [OFFW-1:0] off_o,
    output logic [DW-1:0]   val_o,
    output logic            hit_o
);
    localparam int HW   = WW / 2;
    localparam int BASE = SECT + 7;
    localparam int BW   = $clog2(BASE + 1);
    localparam int DFW  = ((LW > BW) ? LW : BW) + 1;

    logic [WW-1:0]  aw;
    logic [WW-1:0]  vw;
    logic [LW-1:0]  raw;
    logic [DFW-1:0] diff;

    always_comb begin
        aw    = sel_i[1] ? addr2_i : addr1_i;
        vw    = sel_i[1] ? val2_i  : val1_i;
        raw   = sel_i[0] ? aw[HW +: LW] : aw[0 +: LW];
        val_o = sel_i[0] ? vw[HW +: DW] : vw[0 +: DW];
        diff  = DFW'(BASE) - DFW'(raw);
        hit_o = !diff[DFW-1] && (diff < DFW'(SECT));
        off_o = diff[OFFW-1:0];
    end
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
    import ecc_fix_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int TMO_US = 100,
    parameter int SECT   = 512,
    parameter int DW     = 8,
    parameter int LW     = 10,
    parameter int NVAL   = 8,
    parameter int SYNW   = 128,
    parameter int WW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NVAL*LW-1:0]   chk_i,
    output logic                 ld_valid_o,
    output logic [LW-1:0]        ld_data_o,
    input  logic [SYNW-1:0]      syn_i,
    output logic                 loc_go_o,
    input  logic [3:0]           loc_state_i,
    input  logic [1:0]           loc_cnt_i,
    input  logic [WW-1:0]        loc_addr1_i,
    input  logic [WW-1:0]        loc_addr2_i,
    input  logic [WW-1:0]        loc_val1_i,
    input  logic [WW-1:0]        loc_val2_i,
    output logic                 ram_rd_o,
    output logic                 ram_wr_o,
    output logic [$clog2(SECT)-1:0] ram_addr_o,
    input  logic [DW-1:0]        ram_rdata_i,
    output logic [DW-1:0]        ram_wdata_o,
    output logic                 done_o,
    output logic [2:0]           fixed_o,
    output logic                 bad_o
);
    localparam int TMO_CYC = ((CLK_HZ / 1_000_000) * TMO_US > 0) ?
                             (CLK_HZ / 1_000_000) * TMO_US : 1;
    localparam int TW   = $clog2(TMO_CYC + 1);
    localparam int OFFW = $clog2(SECT);
    localparam int IW   = $clog2(NVAL);

    typedef struct packed {
        phase_t          ph;
        logic [IW-1:0]   idx;
        logic [TW-1:0]   tmr;
        logic [2:0]      nerr;
        logic [2:0]      ei;
        logic [OFFW-1:0] off;
        logic [DW-1:0]   val;
        logic [2:0]      fixed;
        logic            bad;
    } st_t;

    st_t st_d, st_q;

    logic [NVAL-1:0][LW-1:0] chk_vals;
    logic [OFFW-1:0]         pk_off;
    logic [DW-1:0]           pk_val;
    logic                    pk_hit;

    ecc_unpack #(.NVAL(NVAL), .LW(LW)) u_unpack (
        .bits_i (chk_i),
        .vals_o (chk_vals)
    );

    ecc_err_pick #(.WW(WW), .LW(LW), .DW(DW), .SECT(SECT), .OFFW(OFFW)) u_pick (
        .sel_i   (st_q.ei[1:0]),
        .addr1_i (loc_addr1_i),
        .addr2_i (loc_addr2_i),
        .val1_i  (loc_val1_i),
        .val2_i  (loc_val2_i),
        .off_o   (pk_off),
        .val_o   (pk_val),
        .hit_o   (pk_hit)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph    = PH_LOAD;
                    st_d.idx   = IW'(NVAL - 1);
                    st_d.fixed = '0;
                    st_d.bad   = 1'b0;
                end
            end
            PH_LOAD: begin
                if (st_q.idx == '0) st_d.ph = PH_SYN;
                else                st_d.idx = st_q.idx - 1'b1;
            end
            PH_SYN: begin
                st_d.ph = (syn_i == '0) ? PH_FIN : PH_KICK;
            end
            PH_KICK: begin
                st_d.tmr = '0;
                st_d.ph  = PH_WAIT;
            end
            PH_WAIT: begin
                if (loc_state_i >= LOC_WORKING || st_q.tmr == TW'(TMO_CYC - 1))
                    st_d.ph = PH_POLL;
                else
                    st_d.tmr = st_q.tmr + 1'b1;
            end
            PH_POLL: begin
                unique case (loc_state_i)
                    LOC_CLEAN: st_d.ph = PH_FIN;
                    LOC_FAIL: begin
                        st_d.bad = 1'b1;
                        st_d.ph  = PH_FIN;
                    end
                    LOC_READYA, LOC_READYB: begin
                        st_d.nerr = {1'b0, loc_cnt_i} + 3'd1;
                        st_d.ei   = '0;
                        st_d.ph   = PH_PICK;
                    end
                    default: st_d.ph = PH_POLL;
                endcase
            end
            PH_PICK: begin
                if (st_q.ei == st_q.nerr) begin
                    st_d.ph = PH_FIN;
                end else if (pk_hit) begin
                    st_d.off = pk_off;
                    st_d.val = pk_val;
                    st_d.ph  = PH_RD;
                end else begin
                    st_d.ei = st_q.ei + 1'b1;
                end
            end
            PH_RD: st_d.ph = PH_WR;
            PH_WR: begin
                st_d.fixed = st_q.fixed + 1'b1;
                st_d.ei    = st_q.ei + 1'b1;
                st_d.ph    = PH_PICK;
            end
            PH_FIN:  st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_valid_o  = (st_q.ph == PH_LOAD);
    assign ld_data_o   = chk_vals[st_q.idx];
    assign loc_go_o    = (st_q.ph == PH_KICK);
    assign ram_rd_o    = (st_q.ph == PH_RD);
    assign ram_wr_o    = (st_q.ph == PH_WR);
    assign ram_addr_o  = st_q.off;
    assign ram_wdata_o = ram_rdata_i ^ st_q.val;
    assign done_o      = (st_q.ph == PH_FIN);
    assign fixed_o     = st_q.fixed;
    assign bad_o       = st_q.bad;
endmodule

// File: rtl/ecc_fix_seq_chk.sv
module ecc_fix_seq_chk #(
    parameter int TMO_CYC = 10000,
    parameter int SYNW    = 128,
    parameter int OFFW    = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            ld_valid_o,
    input logic            loc_go_o,
    input logic [SYNW-1:0] syn_i,
    input logic [3:0]      loc_state_i,
    input logic            ram_rd_o,
    input logic            ram_wr_o,
    input logic [OFFW-1:0] ram_addr_o,
    input logic            done_o,
    input logic [2:0]      fixed_o,
    input logic            bad_o
);
    logic [3:0] ld_cnt;
    logic       kicked;
    logic       seen_busy;
    int         wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_cnt    <= '0;
            kicked    <= 1'b0;
            seen_busy <= 1'b0;
            wcnt      <= 0;
        end else if (start_i && !ld_valid_o && !kicked) begin
            ld_cnt    <= '0;
            seen_busy <= 1'b0;
            wcnt      <= 0;
        end else begin
            if (ld_valid_o && ld_cnt != 4'hF) ld_cnt <= ld_cnt + 1'b1;
            if (loc_go_o) begin
                kicked    <= 1'b1;
                seen_busy <= 1'b0;
                wcnt      <= 0;
            end else if (kicked) begin
                if (loc_state_i >= 4'd4) seen_busy <= 1'b1;
                if (wcnt < TMO_CYC + 8) wcnt <= wcnt + 1;
            end
            if (done_o) begin
                kicked <= 1'b0;
                ld_cnt <= '0;
            end
        end
    end

    assert_kick_after_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_go_o |-> ld_cnt == 4'd8);

    assert_no_kick_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_go_o |-> $past(syn_i) != '0);

    assert_wait_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kicked && (ram_rd_o || done_o)) |-> (seen_busy || wcnt >= TMO_CYC));

    assert_rd_then_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |=> (ram_wr_o && $stable(ram_addr_o)));

    assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_o |-> $past(ram_rd_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_bad_no_fix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(bad_o && fixed_o != 3'd0));
endmodule

bind ecc_fix_seq ecc_fix_seq_chk #(
    .TMO_CYC (TMO_CYC),
    .SYNW    (SYNW),
    .OFFW    (OFFW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ld_valid_o  (ld_valid_o),
    .loc_go_o    (loc_go_o),
    .syn_i       (syn_i),
    .loc_state_i (loc_state_i),
    .ram_rd_o    (ram_rd_o),
    .ram_wr_o    (ram_wr_o),
    .ram_addr_o  (ram_addr_o),
    .done_o      (done_o),
    .fixed_o     (fixed_o),
    .bad_o       (bad_o)
);

// File: tb/ecc_fix_seq_tb.sv
module ecc_fix_seq_tb;
    localparam int TMO = 10000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [79:0]  chk_i = '0;
    logic         ld_valid_o;
    logic [9:0]   ld_data_o;
    logic [127:0] syn_i = '0;
    logic         loc_go_o;
    logic [3:0]   loc_state_i = '0;
    logic [1:0]   loc_cnt_i = '0;
    logic [31:0]  loc_addr1_i = '0, loc_addr2_i = '0, loc_val1_i = '0, loc_val2_i = '0;
    logic         ram_rd_o, ram_wr_o;
    logic [8:0]   ram_addr_o;
    logic [7:0]   ram_rdata_i = '0;
    logic [7:0]   ram_wdata_o;
    logic         done_o;
    logic [2:0]   fixed_o;
    logic         bad_o;

    always #5 clk = ~clk;

    ecc_fix_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_i(chk_i),
        .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o), .syn_i(syn_i),
        .loc_go_o(loc_go_o), .loc_state_i(loc_state_i), .loc_cnt_i(loc_cnt_i),
        .loc_addr1_i(loc_addr1_i), .loc_addr2_i(loc_addr2_i),
        .loc_val1_i(loc_val1_i), .loc_val2_i(loc_val2_i),
        .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o), .ram_addr_o(ram_addr_o),
        .ram_rdata_i(ram_rdata_i), .ram_wdata_o(ram_wdata_o),
        .done_o(done_o), .fixed_o(fixed_o), .bad_o(bad_o)
    );

    // sector RAM model and shadow copy for expectations
    logic [7:0] mem [512];
    logic [7:0] ref_mem [512];
    initial for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) & 255);

    always @(posedge clk) begin
        if (ram_rd_o) ram_rdata_i <= mem[ram_addr_o];
        if (ram_wr_o) mem[ram_addr_o] <= ram_wdata_o;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // locator model
    int          sp = 0, bz = 0;
    logic [3:0]  fin_st = '0;
    bit          always_w = 0;
    logic [31:0] ra1 = '0, ra2 = '0, rv1 = '0, rv2 = '0;
    bit          lact = 0;
    int          lc = 0;

    always @(negedge clk) begin
        if (loc_go_o) begin
            lact = 1; lc = 0;
        end else if (lact) begin
            lc = lc + 1;
        end
        if (done_o) lact = 0;
        if (lact) begin
            loc_state_i = (lc < sp) ? 4'd3 : (lc < sp + bz) ? 4'd9 : fin_st;
            if (always_w || lc >= sp + bz) begin
                loc_addr1_i = ra1; loc_addr2_i = ra2; loc_val1_i = rv1; loc_val2_i = rv2;
            end else begin
                loc_addr1_i = '0; loc_addr2_i = '0; loc_val1_i = '0; loc_val2_i = '0;
            end
        end else begin
            loc_state_i = '0;
            loc_addr1_i = '0; loc_addr2_i = '0; loc_val1_i = '0; loc_val2_i = '0;
        end
    end

    // per-clock comparison against the expected event streams
    logic [9:0]  exp_ld [$];
    logic [16:0] exp_wr [$];
    int mon_tot = 0, mon_bad = 0;
    int kick_n = 0, done_n = 0, done_cyc = 0;
    logic [2:0] done_fixed = '0;
    logic       done_bad = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ld_valid_o) begin
                mon_tot++;
                if (exp_ld.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R2 unexpected load act=%h exp=none", ld_data_o);
                end else begin
                    logic [9:0] e;
                    e = exp_ld.pop_front();
                    if (ld_data_o !== e) begin
                        mon_bad++;
                        $display("FAIL R1/R2 load word act=%h exp=%h", ld_data_o, e);
                    end
                end
            end
            if (ram_wr_o) begin
                mon_tot++;
                if (exp_wr.size() == 0) begin
                    mon_bad++;
                    $display("FAIL R8 unexpected write act=%0d:%h exp=none", ram_addr_o, ram_wdata_o);
                end else begin
                    logic [16:0] w;
                    w = exp_wr.pop_front();
                    if ({ram_addr_o, ram_wdata_o} !== w) begin
                        mon_bad++;
                        $display("FAIL R9 write act=%0d:%h exp=%0d:%h",
                                 ram_addr_o, ram_wdata_o, w[16:8], w[7:0]);
                    end
                end
            end
            if (loc_go_o) kick_n++;
            if (done_o) begin
                done_n++; done_cyc = cyc; done_fixed = fixed_o; done_bad = bad_o;
            end
        end
    end

    int tot = 0, bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input string nm, input logic [79:0] chk, input logic [127:0] syn,
                            input int s, input int b, input logic [3:0] fs, input logic [1:0] cnt,
                            input logic [31:0] a1, input logic [31:0] a2,
                            input logic [31:0] v1, input logic [31:0] v2, input bit aw);
        int   kick0, done0, st_cyc, efix, ekick, eff, n;
        bit   ebad;
        logic [31:0] aa, vv;
        logic [9:0]  raw;
        logic [7:0]  ev;
        int          off;
        kick0 = kick_n; done0 = done_n;
        efix = 0; ebad = 0; ekick = (syn != 0) ? 1 : 0;
        for (int k = 7; k >= 0; k--) exp_ld.push_back(chk[10*k +: 10]);
        eff = (s > TMO) ? 3 : int'(fs);
        if (syn != 0) begin
            if (eff == 1) ebad = 1;
            else if (eff == 2 || eff == 3) begin
                n = int'(cnt) + 1;
                for (int i = 0; i < n; i++) begin
                    aa  = (i < 2) ? a1 : a2;
                    vv  = (i < 2) ? v1 : v2;
                    raw = (i % 2 == 1) ? aa[25:16] : aa[9:0];
                    ev  = (i % 2 == 1) ? vv[23:16] : vv[7:0];
                    off = 519 - int'(raw);
                    if (off >= 0 && off < 512) begin
                        ref_mem[off] = ref_mem[off] ^ ev;
                        exp_wr.push_back({9'(off), ref_mem[off]});
                        efix++;
                    end
                end
            end
        end
        @(negedge clk);
        chk_i = chk; syn_i = syn; sp = s; bz = b; fin_st = fs; loc_cnt_i = cnt;
        ra1 = a1; ra2 = a2; rv1 = v1; rv2 = v2; always_w = aw;
        start_i = 1'b1; st_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        for (int w = 0; w < 30000 && done_n == done0; w++) @(negedge clk);
        check(done_n == done0 + 1, {"R10 watchdog/done ", nm}, done_n - done0, 1);
        repeat (2) @(negedge clk);
        check(done_fixed == 3'(efix), {"R10 fixed count ", nm}, done_fixed, efix);
        check(done_bad == ebad, {"R6 bad flag ", nm}, done_bad, ebad);
        check(kick_n - kick0 == ekick, {"R3/R4 kick count ", nm}, kick_n - kick0, ekick);
        check(exp_ld.size() == 0, {"R2 loads missing ", nm}, exp_ld.size(), 0);
        check(exp_wr.size() == 0, {"R9 writes missing ", nm}, exp_wr.size(), 0);
        if (s > TMO)
            check(done_cyc - st_cyc >= TMO, {"R5 timeout wait ", nm}, done_cyc - st_cyc, TMO);
        begin
            int diffs = 0;
            for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) diffs++;
            check(diffs == 0, {"R9 sector contents ", nm}, diffs, 0);
        end
        exp_ld.delete(); exp_wr.delete();
    endtask

    localparam logic [79:0] CHK_A = {10'h3A5, 10'h1C7, 10'h2F0, 10'h08B,
                                     10'h3FF, 10'h155, 10'h0E2, 10'h2D9};
    localparam logic [79:0] CHK_B = {10'h001, 10'h200, 10'h0AA, 10'h355,
                                     10'h123, 10'h3C0, 10'h07F, 10'h290};

    initial begin
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!ld_valid_o && !loc_go_o, "R11 reset strobes", {ld_valid_o, loc_go_o}, 0);
        check(!ram_rd_o && !ram_wr_o, "R11 reset ram", {ram_rd_o, ram_wr_o}, 0);
        check(!done_o && fixed_o == 0 && !bad_o, "R11 reset result", {done_o, fixed_o, bad_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !ld_valid_o, "R11 idle after reset", {done_o, ld_valid_o}, 0);

        // R3 clean sector: no kick, no ram access
        run_case("clean", CHK_A, '0, 2, 3, 4'd2, 2'd0,
                 32'h0000_0064, 0, 32'h0000_00FF, 0, 0);
        // R6 state 0 after false ready: no correction even though words are present
        run_case("state0", CHK_B, 128'h1, 3, 4, 4'd0, 2'd0,
                 32'h0000_0064, 0, 32'h0000_0042, 0, 1);
        // R6 state 1: uncorrectable
        run_case("uncorr", CHK_A, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 2, 5,
                 4'd1, 2'd3, 32'h0001_0002, 0, 32'h0003_0004, 0, 1);
        // R4 R7 R8 R9 four errors, false ready first, words gated until real result
        run_case("four", CHK_B, 128'h0000_0100_0000_0000_0000_0000_0000_0000, 5, 6,
                 4'd2, 2'd3, 32'hA607_A40A, 32'h0190_00C8,
                 32'h5581_773C, 32'h00FF_0001, 0);
        // R8 offsets out of range are skipped
        run_case("skip", CHK_A, 128'h5, 1, 3, 4'd3, 2'd2,
                 32'h0258_0003, 32'h0000_0008, 32'h00AA_00BB, 32'h0000_0055, 0);
        // R9 two corrections on the same byte see the updated contents
        run_case("same", CHK_B, 128'h10, 2, 2, 4'd3, 2'd1,
                 32'h0064_0064, 0, 32'h00F0_000F, 0, 0);
        // R5 state held at 3 past the timeout
        run_case("timeout", CHK_A, 128'h2, 20000, 0, 4'd3, 2'd0,
                 32'h0000_012C, 0, 32'h0000_0011, 0, 1);

        $display("test done: total=%0d bad=%0d", tot + mon_tot, bad + mon_bad);
        $finish;
    end

    initial begin
        #1_900_000ns;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", tot + mon_tot + 1, bad + mon_bad + 1);
        $finish;
    end
endmodule